// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This unit sits between a processor's data port and the memory fabric. It watches every word access for addresses that fall inside one of two alias windows. In an alias window, each word-aligned address stands for exactly one bit of a backing region. Each backing byte takes 32 bytes of alias space, so one backing bit takes one alias word.

An alias write becomes a locked read-modify-write on the downstream bus. The unit first reads the target word. It then writes that word back with only the chosen bit forced to bit 0 of the write data. An alias read becomes a single downstream read, and the chosen bit is returned in bit 0.

Any address outside both windows goes straight through to the downstream port in the same cycle. Misaligned alias addresses are rejected with an error response. So are alias addresses past the end of the mapped region, which can only occur if a window is decoded wider than 32 times its region. Neither case touches the downstream bus.

Both ports use a request/ready handshake. The requester holds its request, address, write flag and write data stable until it sees ready high at a clock edge. Read data and the error flag are valid in that same cycle.

Top module: `bitband_remap`

## Requirements
- R1: Window 0 takes alias addresses from 0x22000000, spanning 0x100000 bytes by default, onto the 32 KB region at 0x20000000. For alias offset `o = addr - 0x22000000`, the target word is `0x20000000 + ((o >> 5) & ~3)` and the target bit is `o[6:2]`. Bits `o[6:5]` give the byte lane and `o[4:2]` give the bit in that byte.
- R2: An alias write changes only the target bit of the target word, setting it to bit 0 of the write data. All other 31 bits keep their value.
- R3: Window 1 takes alias addresses 0x42000000–0x43FFFFFF onto the 1 MB region at 0x40000000, using the same formula. Writing 1 to 0x4280001C sets bit 7 of the word at 0x40040000. Alias 0x42700004 selects bit 1 of the word at 0x40038000.
- R4: An alias read completes with read data 0x00000000 or 0x00000001, equal to the selected bit.
- R5: An alias write issues exactly two downstream transactions, back to back and with no other transaction between them. The first is a read of the target word. The second is a write to the same address.
- R6: The upstream ready for an alias write is given in the same cycle that the downstream write is accepted, and never earlier.
- R7: A word access outside both windows is forwarded unchanged, with the same address, direction and write data, in the cycle it is presented. Its upstream ready and read data are the downstream ones.
- R8: An alias access whose address is not word-aligned (addr[1:0] != 0) completes with up_err high and makes no downstream transaction.
- R9: An alias access inside a window but at or beyond 32 times the region size from the window base completes with up_err high. It makes no downstream transaction and changes no memory.
- R10: Reset returns the unit to idle and abandons any sequence in flight. With no upstream request, dn_req and up_ready are low right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request valid |
| up_we | input | 1 | Upstream write (1) or read (0) |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_ready | output | 1 | Upstream transfer completes this cycle |
| up_rdata | output | 32 | Upstream read data, valid with up_ready |
| up_err | output | 1 | Error response, valid with up_ready |
| dn_req | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ready | input | 1 | Downstream transfer completes this cycle |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |

## Verification
The bench tries several kinds of alias address.

- The first and last alias words of a window tell apart bit 0 and bit 31 of the same word.
- Neighbouring alias words tell the byte-lane field apart from the bit-in-byte field.
- A write whose data is 0xFFFFFFFE checks that only bit 0 of the write data is used.
- Pass-through reads of the backing words after each alias write show whether any other bit moved.
- Counting downstream transactions per request separates pass-through, a single alias read, the read-then-write pair and rejected accesses.
- A slow memory, ready only every second cycle, exposes any early upstream ready.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    localparam int WORD_W   = 32;
    localparam int BIDX_W   = $clog2(WORD_W);
    localparam int NWIN     = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FAULT = 2'd3
    } bbr_state_e;

    typedef struct packed {
        bbr_state_e              st;
        logic                    is_wr;
        logic                    set_val;
        logic [BIDX_W-1:0]       bit_idx;
        logic [WORD_W-1:0]       tgt;
        logic [WORD_W-1:0]       word;
    } bbr_ctx_t;
endpackage

// File: rtl/bbr_window_dec.sv
module bbr_window_dec
    import bbr_pkg::*;
#(
    parameter logic [WORD_W-1:0] ALIAS_BASE = 32'h2200_0000,
    parameter logic [WORD_W-1:0] SPAN       = 32'h0010_0000,
    parameter logic [WORD_W-1:0] MAP_BASE   = 32'h2000_0000,
    parameter logic [WORD_W-1:0] MAP_BYTES  = 32'h0000_8000
) (
    input  logic [WORD_W-1:0] addr,
    output logic              hit,
    output logic              legal,
    output logic [WORD_W-1:0] tgt,
    output logic [BIDX_W-1:0] bit_idx
);
    // Alias bytes consumed by the mapped region: one word per backing bit.
    localparam logic [WORD_W-1:0] MAP_ALIAS = MAP_BYTES << 5;

    logic [WORD_W-1:0] off;

    always_comb begin
        off     = addr - ALIAS_BASE;
        hit     = (off < SPAN);
        legal   = hit && (off < MAP_ALIAS) && (addr[1:0] == 2'b00);
        // byte offset = off >> 5, then aligned down to a word
        tgt     = MAP_BASE + {5'b0, off[WORD_W-1:7], 2'b00};
        // byte lane in off[6:5], bit within byte in off[4:2]
        bit_idx = off[6:2];
    end
endmodule

// File: rtl/bbr_bit_lane.sv
module bbr_bit_lane
    import bbr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [BIDX_W-1:0] bit_idx,
    input  logic              set_val,
    output logic [WORD_W-1:0] merged,
    output logic              picked
);
    always_comb begin
        merged = word_in;
        picked = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (bit_idx == i[BIDX_W-1:0]) begin
                merged[i] = set_val;
                picked    = word_in[i];
            end
        end
    end
endmodule

// File: rtl/bitband_remap.sv
module bitband_remap
    import bbr_pkg::*;
#(
    parameter logic [31:0] W0_ALIAS = 32'h2200_0000,
    parameter logic [31:0] W0_SPAN  = 32'h0010_0000,
    parameter logic [31:0] W0_BASE  = 32'h2000_0000,
    parameter logic [31:0] W0_BYTES = 32'h0000_8000,
    parameter logic [31:0] W1_ALIAS = 32'h4200_0000,
    parameter logic [31:0] W1_SPAN  = 32'h0200_0000,
    parameter logic [31:0] W1_BASE  = 32'h4000_0000,
    parameter logic [31:0] W1_BYTES = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_req,
    input  logic        up_we,
    input  logic [31:0] up_addr,
    input  logic [31:0] up_wdata,
    output logic        up_ready,
    output logic [31:0] up_rdata,
    output logic        up_err,
    output logic        dn_req,
    output logic        dn_we,
    output logic [31:0] dn_addr,
    output logic [31:0] dn_wdata,
    input  logic        dn_ready,
    input  logic [31:0] dn_rdata
);
    localparam logic [NWIN-1:0][WORD_W-1:0] A_BASE = {W1_ALIAS, W0_ALIAS};
    localparam logic [NWIN-1:0][WORD_W-1:0] A_SPAN = {W1_SPAN,  W0_SPAN};
    localparam logic [NWIN-1:0][WORD_W-1:0] M_BASE = {W1_BASE,  W0_BASE};
    localparam logic [NWIN-1:0][WORD_W-1:0] M_SIZE = {W1_BYTES, W0_BYTES};

    logic [NWIN-1:0]              win_hit;
    logic [NWIN-1:0]              win_legal;
    logic [NWIN-1:0][WORD_W-1:0]  win_tgt;
    logic [NWIN-1:0][BIDX_W-1:0]  win_bit;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bbr_window_dec #(
            .ALIAS_BASE (A_BASE[g]),
            .SPAN       (A_SPAN[g]),
            .MAP_BASE   (M_BASE[g]),
            .MAP_BYTES  (M_SIZE[g])
        ) u_dec (
            .addr    (up_addr),
            .hit     (win_hit[g]),
            .legal   (win_legal[g]),
            .tgt     (win_tgt[g]),
            .bit_idx (win_bit[g])
        );
    end

    logic              any_hit;
    logic              sel_legal;
    logic [WORD_W-1:0] sel_tgt;
    logic [BIDX_W-1:0] sel_bit;

    always_comb begin
        any_hit   = 1'b0;
        sel_legal = 1'b0;
        sel_tgt   = '0;
        sel_bit   = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (win_hit[w]) begin
                any_hit   = 1'b1;
                sel_legal = win_legal[w];
                sel_tgt   = win_tgt[w];
                sel_bit   = win_bit[w];
            end
        end
    end

    bbr_ctx_t ctx_d, ctx_q;

    logic [WORD_W-1:0] merged_word;
    logic              picked_bit;

    bbr_bit_lane u_lane (
        .word_in (dn_rdata),
        .bit_idx (ctx_q.bit_idx),
        .set_val (ctx_q.set_val),
        .merged  (merged_word),
        .picked  (picked_bit)
    );

    always_comb begin
        ctx_d    = ctx_q;
        up_ready = 1'b0;
        up_rdata = '0;
        up_err   = 1'b0;
        dn_req   = 1'b0;
        dn_we    = 1'b0;
        dn_addr  = '0;
        dn_wdata = '0;

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (up_req && !any_hit) begin
                    dn_req   = 1'b1;
                    dn_we    = up_we;
                    dn_addr  = up_addr;
                    dn_wdata = up_wdata;
                    up_ready = dn_ready;
                    up_rdata = dn_rdata;
                end else if (up_req && !sel_legal) begin
                    ctx_d.st = ST_FAULT;
                end else if (up_req) begin
                    ctx_d.st      = ST_READ;
                    ctx_d.is_wr   = up_we;
                    ctx_d.set_val = up_wdata[0];
                    ctx_d.bit_idx = sel_bit;
                    ctx_d.tgt     = sel_tgt;
                end
            end
            ST_READ: begin
                dn_req  = 1'b1;
                dn_addr = ctx_q.tgt;
                if (dn_ready) begin
                    if (ctx_q.is_wr) begin
                        ctx_d.word = merged_word;
                        ctx_d.st   = ST_WRITE;
                    end else begin
                        up_ready = 1'b1;
                        up_rdata = {{(WORD_W-1){1'b0}}, picked_bit};
                        ctx_d.st = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = ctx_q.tgt;
                dn_wdata = ctx_q.word;
                if (dn_ready) begin
                    up_ready = 1'b1;
                    ctx_d.st = ST_IDLE;
                end
            end
            ST_FAULT: begin
                up_ready = 1'b1;
                up_err   = 1'b1;
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, is_wr: 1'b0, set_val: 1'b0,
                       bit_idx: '0, tgt: '0, word: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end
endmodule

// File: rtl/bitband_remap_chk.sv
module bitband_remap_chk
    import bbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bbr_state_e  st,
    input  logic        is_wr,
    input  logic        up_we,
    input  logic [31:0] up_addr,
    input  logic        up_ready,
    input  logic [31:0] up_rdata,
    input  logic        up_err,
    input  logic        dn_req,
    input  logic        dn_we,
    input  logic [31:0] dn_addr,
    input  logic [31:0] dn_wdata,
    input  logic        dn_ready,
    input  logic [31:0] dn_rdata
);
    logic [31:0] rd_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cap <= '0;
        else if (st == ST_READ && dn_req && dn_ready) rd_cap <= dn_rdata;
    end

    // R2
    single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE && dn_req) |-> ($countones(dn_wdata ^ rd_cap) <= 1));

    // R4
    alias_read_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && !is_wr && up_ready) |-> (up_rdata[31:1] == 31'd0));

    // R5
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && is_wr && dn_req && dn_ready) |=>
        (dn_req && dn_we && dn_addr == $past(dn_addr)));

    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && is_wr) |-> !up_ready);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && dn_req) |-> (dn_addr == up_addr && dn_we == up_we));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> (!dn_req && up_ready));
endmodule

bind bitband_remap bitband_remap_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (ctx_q.st),
    .is_wr    (ctx_q.is_wr),
    .up_we    (up_we),
    .up_addr  (up_addr),
    .up_ready (up_ready),
    .up_rdata (up_rdata),
    .up_err   (up_err),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_ready (dn_ready),
    .dn_rdata (dn_rdata)
);

// File: tb/bitband_remap_tb.sv
module bitband_remap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0;
    logic        up_we = 1'b0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic        up_err;
    logic        dn_req;
    logic        dn_we;
    logic [31:0] dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_ready;
    logic [31:0] dn_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Window 0 decoded twice as wide as its mapped span, so R9 can be reached.
    bitband_remap #(.W0_SPAN(32'h0020_0000)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ready(dn_ready), .dn_rdata(dn_rdata)
    );

    // Memory model: ready on every second cycle of a held request.
    logic [31:0] mem [logic [31:0]];
    logic        gap;
    int          n_rd, n_wr;
    logic [31:0] rd_a, wr_a;

    assign dn_ready = dn_req & gap;

    always_comb begin
        logic [31:0] a;
        a = {dn_addr[31:2], 2'b00};
        dn_rdata = mem.exists(a) ? mem[a] : 32'h0;
    end

    always @(posedge clk) begin
        if (!rst_n) gap <= 1'b0;
        else        gap <= dn_req ? ~gap : 1'b0;
        if (dn_req && dn_ready) begin
            if (dn_we) begin
                mem[{dn_addr[31:2], 2'b00}] = dn_wdata;
                n_wr <= n_wr + 1;
                wr_a <= dn_addr;
            end else begin
                n_rd <= n_rd + 1;
                rd_a <= dn_addr;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Kinds: 0 pass write, 1 pass read, 2 alias write, 3 alias read, 4 error
    typedef struct packed {
        logic [2:0]  kind;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [31:0] dna;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b1, 32'h4004_0000, 32'h0000_0F00, 32'h0, 32'h4004_0000, 8'd7},  // R7
        '{3'd2, 1'b1, 32'h4280_001C, 32'h0000_0001, 32'h0, 32'h4004_0000, 8'd3},  // R3
        '{3'd1, 1'b0, 32'h4004_0000, 32'h0,         32'h0000_0F80, 32'h4004_0000, 8'd2}, // R2
        '{3'd3, 1'b0, 32'h4280_0020, 32'h0,         32'h1, 32'h4004_0000, 8'd4},  // R4
        '{3'd2, 1'b1, 32'h4280_0024, 32'hFFFF_FFFE, 32'h0, 32'h4004_0000, 8'd2},  // R2
        '{3'd1, 1'b0, 32'h4004_0000, 32'h0,         32'h0000_0D80, 32'h4004_0000, 8'd2}, // R2
        '{3'd0, 1'b1, 32'h4003_8000, 32'h0000_0002, 32'h0, 32'h4003_8000, 8'd7},  // R7
        '{3'd3, 1'b0, 32'h4270_0004, 32'h0,         32'h1, 32'h4003_8000, 8'd3},  // R3
        '{3'd3, 1'b0, 32'h4270_0008, 32'h0,         32'h0, 32'h4003_8000, 8'd4},  // R4
        '{3'd0, 1'b1, 32'h2000_7FFC, 32'hA5A5_A5A5, 32'h0, 32'h2000_7FFC, 8'd7},  // R7
        '{3'd2, 1'b1, 32'h220F_FF80, 32'h0,         32'h0, 32'h2000_7FFC, 8'd1},  // R1 bit 0
        '{3'd2, 1'b1, 32'h220F_FFFC, 32'h0,         32'h0, 32'h2000_7FFC, 8'd1},  // R1 bit 31
        '{3'd1, 1'b0, 32'h2000_7FFC, 32'h0,         32'h25A5_A5A4, 32'h2000_7FFC, 8'd1}, // R1
        '{3'd2, 1'b1, 32'h2200_0020, 32'h0000_0001, 32'h0, 32'h2000_0000, 8'd1},  // R1 lane 1
        '{3'd1, 1'b0, 32'h2000_0000, 32'h0,         32'h0000_0100, 32'h2000_0000, 8'd1}, // R1
        '{3'd2, 1'b1, 32'h43FF_FFFC, 32'h0000_0001, 32'h0, 32'h400F_FFFC, 8'd3},  // R3
        '{3'd1, 1'b0, 32'h400F_FFFC, 32'h0,         32'h8000_0000, 32'h400F_FFFC, 8'd3}, // R3
        '{3'd4, 1'b1, 32'h2200_0002, 32'h0000_0001, 32'h0, 32'h0, 8'd8},          // R8
        '{3'd4, 1'b0, 32'h4200_000D, 32'h0,         32'h0, 32'h0, 8'd8},          // R8
        '{3'd4, 1'b1, 32'h2210_0000, 32'h0000_0001, 32'h0, 32'h0, 8'd9},          // R9
        '{3'd4, 1'b0, 32'h221F_FFFC, 32'h0,         32'h0, 32'h0, 8'd9},          // R9
        '{3'd1, 1'b0, 32'h2000_7FFC, 32'h0,         32'h25A5_A5A4, 32'h2000_7FFC, 8'd9}, // R9
        '{3'd3, 1'b0, 32'h43FF_FFFC, 32'h0,         32'h1, 32'h400F_FFFC, 8'd4}   // R4
    };

    task automatic run_vec(input vec_t v);
        logic [31:0] got_rd;
        logic        got_err;
        logic        wr_at_ready;
        int          wait_n;
        string       tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        up_req = 1'b1; up_we = v.we; up_addr = v.addr; up_wdata = v.wdata;
        wait_n = 0;
        while (!up_ready && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        got_rd = up_rdata;
        got_err = up_err;
        wr_at_ready = dn_req && dn_we && dn_ready;
        chk(up_ready, {tag, " completion"}, 32'(up_ready), 32'd1);
        @(posedge clk);
        #1;
        up_req = 1'b0;
        case (v.kind)
            3'd0: chk(!got_err && n_wr == 1 && wr_a == v.dna, {tag, " pass write"},
                      wr_a, v.dna);
            3'd1: begin
                chk(!got_err && got_rd == v.exp, {tag, " read data"}, got_rd, v.exp);
                chk(n_rd == 1 && n_wr == 0 && rd_a == v.dna, {tag, " pass read addr"},
                    rd_a, v.dna);
            end
            3'd2: begin
                // R5: one read then one write of the same target word
                chk(!got_err && n_rd == 1 && n_wr == 1 && rd_a == v.dna && wr_a == v.dna,
                    {tag, " R5 rmw pair"}, wr_a, v.dna);
                // R6: upstream ready coincides with the downstream write
                chk(wr_at_ready, {tag, " R6 ready with write"}, 32'(wr_at_ready), 32'd1);
            end
            3'd3: begin
                chk(!got_err && got_rd == v.exp, {tag, " alias read bit"}, got_rd, v.exp);
                chk(n_rd == 1 && n_wr == 0 && rd_a == v.dna, {tag, " alias read addr"},
                    rd_a, v.dna);
            end
            default: begin
                chk(got_err, {tag, " error flag"}, 32'(got_err), 32'd1);
                chk(n_rd == 0 && n_wr == 0, {tag, " no downstream"}, 32'(n_rd + n_wr), 32'd0);
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: idle at reset
        chk(!dn_req && !up_ready, "R10 in reset", {30'd0, dn_req, up_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dn_req && !up_ready, "R10 after reset", {30'd0, dn_req, up_ready}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R7: pass-through presented in the same cycle
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b1; up_addr = 32'h6000_0010; up_wdata = 32'h1234_5678;
        #1;
        chk(dn_req && dn_we && dn_addr == 32'h6000_0010 && dn_wdata == 32'h1234_5678,
            "R7 same-cycle forward", dn_wdata, 32'h1234_5678);
        while (!up_ready) @(negedge clk);
        @(posedge clk);
        #1;
        up_req = 1'b0;

        // R10: reset mid-sequence abandons the alias write
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b1; up_addr = 32'h2200_0004; up_wdata = 32'h1;
        @(negedge clk);
        chk(dn_req && !dn_we, "R10 sequence started", 32'(dn_req), 32'd1);
        up_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dn_req && !up_ready, "R10 abandoned", {30'd0, dn_req, up_ready}, 32'd0);
        run_vec('{3'd1, 1'b0, 32'h2000_0000, 32'h0, 32'h0000_0100, 32'h2000_0000, 8'd10});

        finish_run();
    end
endmodule